// File: doc/BRIEF.md
# Processor Cluster Reset Controller

This block holds the reset state of a four-core processor cluster and its shared L2 cache in one 32-bit control register. Software writes the register through a plain write strobe and reads it back at any time. The block drives level reset lines straight from the register bits: one warm reset and one power-on reset per core, plus the L2 reset. All of these lines are active high.

The block also watches each core's warm reset bit. A write that changes that bit produces one single-cycle request pulse for that core. If the bit rises, the pulse asks for the core to be powered off. If the bit falls, the pulse asks for the core to be powered on and reset. A write that leaves the bit as it was produces no request. Several cores can receive requests from the same write. The block does not sequence core power itself. The bus fabric that produces the writes is outside this block.

Top module: `cluster_rst_ctrl`

## Requirements
- R1: While reset is asserted and on its release, the register reads 0x00003D0F, and no request pulse is high.
- R2: Bits 4 to 7, 9, 14 and 15 (mask 0xC2F0) always read as 0 and ignore written values. Every other bit, including bits 16 to 31, reads back the last value written.
- R3: The level reset outputs follow the register, active high. `core_warm_rst[i]` is bit i for i = 0..3. `core_por_rst[i]` is bit 10+i. `l2_rst` is bit 8.
- R4: A write that takes core i's warm reset bit from 0 to 1 raises `off_req[i]`. The pulse starts in the cycle in which the register shows the new value.
- R5: A write that takes core i's warm reset bit from 1 to 0 raises `on_req[i]`. The pulse starts in the cycle in which the register shows the new value.
- R6: A write that leaves a core's warm reset bit unchanged produces no request for that core. A cycle with `wr_en` low changes neither the register nor the requests. A change to a power-on reset bit or to the L2 bit produces no request.
- R7: One write that changes several warm reset bits produces the matching off and on requests for all of those cores in the same cycle.
- R8: Each request lasts exactly one cycle. Writing the same value again in the next cycle does not extend it.
- R9: While reset is asserted, no request pulse is produced, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Value to write |
| rd_data | output | 32 | Current register value, reserved bits zero |
| core_warm_rst | output | 4 | Per-core warm reset level, active high |
| core_por_rst | output | 4 | Per-core power-on reset level, active high |
| l2_rst | output | 1 | Shared L2 reset level, active high |
| off_req | output | 4 | Per-core power-off request pulse |
| on_req | output | 4 | Per-core power-on-and-reset request pulse |

## Verification
Two functions can coincide in one cycle: a power-off request to one core and a power-on request to another. The bench provokes this with one write in which some warm reset bits rise and others fall. It then checks that `off_req` and `on_req` carry exactly the rising and falling sets in the cycle in which the new register value appears. It also checks that no core ever has both pulses high at once.

// File: rtl/cluster_rst_pkg.sv
package cluster_rst_pkg;
  localparam int unsigned CRC_REG_W     = 32;
  localparam int unsigned CRC_CORES     = 4;
  localparam int unsigned CRC_WARM_LSB  = 0;
  localparam int unsigned CRC_POR_LSB   = 10;
  localparam int unsigned CRC_L2_BIT    = 8;
  localparam logic [CRC_REG_W-1:0] CRC_RESET_VAL = 32'h0000_3D0F;
  localparam logic [CRC_REG_W-1:0] CRC_RSVD_MASK = 32'h0000_C2F0;

  // Request encoding for a single core.
  typedef struct packed {
    logic off;
    logic on;
  } core_req_t;
endpackage

// File: rtl/crc_ctrl_reg.sv
module crc_ctrl_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter logic [W-1:0] RSVD_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] KEEP = ~RSVD_MASK;
  localparam logic [W-1:0] INIT = RESET_VAL & KEEP;

  // Reserved bits never hold a one.
  assign nxt = wr_en ? (wr_data & KEEP) : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= nxt;
  end
endmodule

// File: rtl/crc_edge_req.sv
module crc_edge_req
  import cluster_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cur_bit,
  input  logic      nxt_bit,
  output core_req_t req
);
  core_req_t req_d;

  // Rising warm reset bit asks for power-off, falling bit for power-on.
  always_comb begin
    req_d.off = ~cur_bit &  nxt_bit;
    req_d.on  =  cur_bit & ~nxt_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= req_d;
  end
endmodule

// File: rtl/cluster_rst_ctrl.sv
module cluster_rst_ctrl
  import cluster_rst_pkg::*;
#(
  parameter int unsigned REG_W    = CRC_REG_W,
  parameter int unsigned CORES    = CRC_CORES,
  parameter int unsigned WARM_LSB = CRC_WARM_LSB,
  parameter int unsigned POR_LSB  = CRC_POR_LSB,
  parameter int unsigned L2_BIT   = CRC_L2_BIT,
  parameter logic [REG_W-1:0] RESET_VAL = CRC_RESET_VAL,
  parameter logic [REG_W-1:0] RSVD_MASK = CRC_RSVD_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [CORES-1:0] core_warm_rst,
  output logic [CORES-1:0] core_por_rst,
  output logic             l2_rst,
  output logic [CORES-1:0] off_req,
  output logic [CORES-1:0] on_req
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_nxt;

  crc_ctrl_reg #(
    .W        (REG_W),
    .RESET_VAL(RESET_VAL),
    .RSVD_MASK(RSVD_MASK)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .q      (reg_q),
    .nxt    (reg_nxt)
  );

  for (genvar c = 0; c < CORES; c++) begin : g_core
    core_req_t req;

    crc_edge_req u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_bit(reg_q[WARM_LSB + c]),
      .nxt_bit(reg_nxt[WARM_LSB + c]),
      .req    (req)
    );

    assign off_req[c]       = req.off;
    assign on_req[c]        = req.on;
    assign core_warm_rst[c] = reg_q[WARM_LSB + c];
    assign core_por_rst[c]  = reg_q[POR_LSB + c];
  end

  assign l2_rst  = reg_q[L2_BIT];
  assign rd_data = reg_q;
endmodule

// File: rtl/cluster_rst_ctrl_chk.sv
module cluster_rst_ctrl_chk #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned CORES    = 4,
  parameter int unsigned WARM_LSB = 0,
  parameter logic [REG_W-1:0] RSVD_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic [CORES-1:0] core_warm_rst,
  input logic [CORES-1:0] off_req,
  input logic [CORES-1:0] on_req
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD_MASK) == '0);

  a_r3_warm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    core_warm_rst == rd_data[WARM_LSB +: CORES]);

  a_r4_off_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    off_req == (~$past(rd_data[WARM_LSB +: CORES]) & rd_data[WARM_LSB +: CORES]));

  a_r5_on_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    on_req == ($past(rd_data[WARM_LSB +: CORES]) & ~rd_data[WARM_LSB +: CORES]));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (off_req == '0 && on_req == '0 && $stable(rd_data)));

  a_r7_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req & on_req) == '0);

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (off_req == '0 && on_req == '0));
endmodule

bind cluster_rst_ctrl cluster_rst_ctrl_chk #(
  .REG_W    (REG_W),
  .CORES    (CORES),
  .WARM_LSB (WARM_LSB),
  .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_data      (rd_data),
  .core_warm_rst(core_warm_rst),
  .off_req      (off_req),
  .on_req       (on_req)
);

// File: tb/tb_cluster_rst_ctrl.sv
module tb_cluster_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // Stimulus and expected results; each row starts from the previous row's state.
  localparam logic [31:0] V_WR  [NVEC] = '{32'h0000_3D0E, 32'h0000_3D0E, 32'h0000_0000,
                                          32'hFFFF_FFFF, 32'h0000_3D0A, 32'h0000_0C05,
                                          32'h0000_3CF5, 32'h0000_0105};
  localparam logic [31:0] V_RD  [NVEC] = '{32'h0000_3D0E, 32'h0000_3D0E, 32'h0000_0000,
                                          32'hFFFF_3D0F, 32'h0000_3D0A, 32'h0000_0C05,
                                          32'h0000_3C05, 32'h0000_0105};
  localparam logic [3:0]  V_OFF [NVEC] = '{4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h5, 4'h0, 4'h0};
  localparam logic [3:0]  V_ON  [NVEC] = '{4'h1, 4'h0, 4'hE, 4'h0, 4'h5, 4'hA, 4'h0, 4'h0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  core_warm_rst, core_por_rst, off_req, on_req;
  logic        l2_rst;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_rst_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_warm_rst(core_warm_rst), .core_por_rst(core_por_rst), .l2_rst(l2_rst),
    .off_req(off_req), .on_req(on_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_levels(input string tag, input logic [31:0] exp_rd);
    chk({tag, " R3 warm"}, {28'h0, core_warm_rst}, {28'h0, exp_rd[3:0]});
    chk({tag, " R3 por"},  {28'h0, core_por_rst},  {28'h0, exp_rd[13:10]});
    chk({tag, " R3 l2"},   {31'h0, l2_rst},        {31'h0, exp_rd[8]});
  endtask

  // Drive a write at a falling edge; sample just after the next rising edge.
  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'hA5A5_5A5A;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd in reset", rd_data, 32'h0000_3D0F);
    chk("R1 off in reset", {28'h0, off_req}, 32'h0);
    chk("R1 on in reset", {28'h0, on_req}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1;
    chk("R1 rd after release", rd_data, 32'h0000_3D0F);
    chk_levels("R1", 32'h0000_3D0F);

    for (int i = 0; i < NVEC; i++) begin
      do_write(V_WR[i]);
      chk($sformatf("R2 vec%0d rd", i), rd_data, V_RD[i]);
      chk($sformatf("R4 R7 vec%0d off", i), {28'h0, off_req}, {28'h0, V_OFF[i]});
      chk($sformatf("R5 R7 vec%0d on", i), {28'h0, on_req}, {28'h0, V_ON[i]});
      chk_levels($sformatf("vec%0d", i), V_RD[i]);
    end

    // R8: rewrite the same value right after a change; pulse must not stretch.
    do_write(32'h0000_0000);
    chk("R5 single on", {28'h0, on_req}, 32'h5);
    do_write(32'h0000_0000);
    chk("R8 off after one cycle", {28'h0, off_req}, 32'h0);
    chk("R8 on after one cycle", {28'h0, on_req}, 32'h0);

    // R6: strobe low ignores the data bus.
    idle_cycle();
    chk("R6 rd held", rd_data, 32'h0);
    chk("R6 no off", {28'h0, off_req}, 32'h0);
    chk("R6 no on", {28'h0, on_req}, 32'h0);

    // R9: reset taken while a write is pending.
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h0000_000F;
    rst_n = 1'b0;
    @(posedge clk) #1;
    chk("R9 off in reset", {28'h0, off_req}, 32'h0);
    chk("R9 on in reset", {28'h0, on_req}, 32'h0);
    chk("R9 write ignored", rd_data, 32'h0000_3D0F);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk) #1;
    chk("R9 quiet after release", {24'h0, off_req, on_req}, 32'h0);
    chk_levels("R9", 32'h0000_3D0F);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule